// File: doc/BRIEF.md
# Six-Channel Split-Count PWM Controller

This block generates six independent pulse-width waveforms, each set by two cycle counts. A small register bus sets them up. Each channel has a control word, whose top bit turns the channel on, and a timing word. The timing word packs a 16-bit high-phase length and a 16-bit low-phase length. While a channel is enabled, its output is high for the high count, then low for the low count, and the pattern repeats.

Software can rewrite a timing word at any time. The period already under way finishes with the counts it started with, and the new counts apply from the next period boundary. Clearing the enable bit does not wait: the output drops low in the cycle after the write. Re-enabling starts a fresh period at the beginning of the high phase.

Top module: `hl_pwm_ctrl`

## Requirements
- R1: There are six channels, each running on its own. Channel c has its control word at byte address 4*c and its timing word at byte address 0x20 + 4*c. Bit 31 of the control word is the enable. In the timing word, bits [31:16] give the high count and bits [15:0] give the low count, both in clock cycles.
- R2: After reset every register reads as zero and every output is low.
- R3: A read, strobed for one cycle, returns data one cycle later. For a mapped register that data is the last value written to it. Control bits other than bit 31 are stored but leave the output low. Addresses outside the two register banks read as zero, and writes to them are dropped.
- R4: An enabled channel is high for exactly the high count, then low for exactly the low count, and repeats this without gaps.
- R5: When the write that sets the enable bit is taken at clock edge k, the output is still low after edge k and is high after edge k+1 (when the high count is nonzero). This fresh period uses the timing word current at that moment.
- R6: When the write that clears the enable bit is taken at edge k, the output is low after edge k, whatever phase it was in, and it stays low.
- R7: If a timing word is rewritten in the middle of a period, that period completes with its old counts, and the new counts govern every period after it.
- R8: If a timing write is taken on the very edge that ends a period, the period that starts at that edge already uses the new counts.
- R9: A high count of zero keeps the output low. A low count of zero keeps it high while enabled. Both counts zero keeps it low.
- R10: A high count of 0xFFFF gives 65535 high cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| wr_en_i | input | 1 | Single-cycle write strobe |
| rd_en_i | input | 1 | Single-cycle read strobe |
| addr_i | input | 8 | Byte address |
| wdata_i | input | 32 | Write data |
| rdata_o | output | 32 | Registered read data, valid one cycle after rd_en_i |
| pwm_o | output | 6 | Waveform outputs, bit c for channel c |

## Verification
A period boundary and a timing write can both fall on the same clock edge. The bench enables a channel and counts edges from the enable write, so that it can land a timing write exactly on the edge that ends the first period. It then samples the output every cycle and checks that the very next high phase already has the new length, with no extra period at the old counts. A second run places the write in the middle of a high phase and expects one full period at the old counts before the change.

// File: rtl/pwm_pkg.sv
package pwm_pkg;
  localparam int DATA_W   = 32;
  localparam int SLOT_LSB = 2;   // word aligned
  localparam int BANK_LSB = 5;   // 8 words per bank
  localparam int SLOT_W   = BANK_LSB - SLOT_LSB;
  localparam int EN_BIT   = 31;
  localparam int HI_LSB   = 16;
  localparam int CTRL_BANK = 0;
  localparam int TIM_BANK  = 1;
endpackage

// File: rtl/pwm_regfile.sv
module pwm_regfile
  import pwm_pkg::*;
#(
  parameter int N_CH   = 6,
  parameter int CNT_W  = 16,
  parameter int ADDR_W = 8
) (
  input  logic                             clk_i,
  input  logic                             rst_ni,
  input  logic                             wr_en_i,
  input  logic                             rd_en_i,
  input  logic [ADDR_W-1:0]                addr_i,
  input  logic [DATA_W-1:0]                wdata_i,
  output logic [DATA_W-1:0]                rdata_o,
  output logic [N_CH-1:0]                  en_o,
  output logic [N_CH-1:0][2*CNT_W-1:0]     tim_o
);
  localparam int BANK_W = ADDR_W - BANK_LSB;

  logic [N_CH-1:0][DATA_W-1:0] ctrl_q, tim_q;
  logic [BANK_W-1:0] bank;
  logic [SLOT_W-1:0] slot;
  logic slot_ok, hit_ctrl, hit_tim;
  logic [DATA_W-1:0] rd_mux, rdata_q;

  assign bank     = addr_i[ADDR_W-1:BANK_LSB];
  assign slot     = addr_i[BANK_LSB-1:SLOT_LSB];
  assign slot_ok  = int'(slot) < N_CH;
  assign hit_ctrl = slot_ok && (bank == BANK_W'(CTRL_BANK));
  assign hit_tim  = slot_ok && (bank == BANK_W'(TIM_BANK));

  for (genvar ch = 0; ch < N_CH; ch++) begin : g_ch
    logic wr_ctrl, wr_tim;
    assign wr_ctrl = wr_en_i && hit_ctrl && (slot == SLOT_W'(ch));
    assign wr_tim  = wr_en_i && hit_tim  && (slot == SLOT_W'(ch));

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        ctrl_q[ch] <= '0;
        tim_q[ch]  <= '0;
      end else begin
        if (wr_ctrl) ctrl_q[ch] <= wdata_i;
        if (wr_tim)  tim_q[ch]  <= wdata_i;
      end
    end

    assign en_o[ch] = ctrl_q[ch][EN_BIT];
    // bypass so a write on the boundary edge is seen by the reload
    assign tim_o[ch] = wr_tim ? {wdata_i[HI_LSB +: CNT_W], wdata_i[0 +: CNT_W]}
                              : {tim_q[ch][HI_LSB +: CNT_W], tim_q[ch][0 +: CNT_W]};
  end

  always_comb begin
    rd_mux = '0;
    for (int ch = 0; ch < N_CH; ch++) begin
      if (slot == SLOT_W'(ch)) begin
        if (hit_ctrl) rd_mux = ctrl_q[ch];
        if (hit_tim)  rd_mux = tim_q[ch];
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      rdata_q <= '0;
    else if (rd_en_i) rdata_q <= rd_mux;
  end

  assign rdata_o = rdata_q;

  // R3
  unmapped_rd_zero_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_en_i && !hit_ctrl && !hit_tim) |=> (rdata_o == '0));
endmodule

// File: rtl/pwm_chan.sv
module pwm_chan #(
  parameter int CNT_W = 16
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               en_i,
  input  logic [2*CNT_W-1:0] tim_i,
  output logic               pwm_o
);
  localparam int PER_W = CNT_W + 1;

  logic             run_q;
  logic [PER_W-1:0] cnt_q, period;
  logic [CNT_W-1:0] hi_q, lo_q;
  logic             last;

  assign period = PER_W'(hi_q) + PER_W'(lo_q);
  assign last   = (period == '0) || (cnt_q == period - PER_W'(1));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      run_q <= 1'b0;
      cnt_q <= '0;
      hi_q  <= '0;
      lo_q  <= '0;
    end else if (!en_i) begin
      run_q <= 1'b0;
      cnt_q <= '0;
    end else if (!run_q || last) begin
      run_q <= 1'b1;
      cnt_q <= '0;
      hi_q  <= tim_i[CNT_W +: CNT_W];
      lo_q  <= tim_i[0 +: CNT_W];
    end else begin
      cnt_q <= cnt_q + PER_W'(1);
    end
  end

  assign pwm_o = en_i && run_q && (cnt_q < PER_W'(hi_q));

  // R7
  act_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (en_i && run_q && !last) |=> ($stable(hi_q) && $stable(lo_q)));
  // R4
  cnt_step_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (en_i && run_q && !last) |=> (cnt_q == $past(cnt_q) + PER_W'(1)));
  // R5
  start_high_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($rose(run_q) && en_i) |-> ((cnt_q == '0) && (pwm_o == (hi_q != '0))));
  // R9
  zero_hi_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (run_q && (hi_q == '0)) |-> !pwm_o);
endmodule

// File: rtl/hl_pwm_ctrl.sv
module hl_pwm_ctrl
  import pwm_pkg::*;
#(
  parameter int N_CH   = 6,
  parameter int CNT_W  = 16,
  parameter int ADDR_W = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_en_i,
  input  logic              rd_en_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [31:0]       wdata_i,
  output logic [31:0]       rdata_o,
  output logic [N_CH-1:0]   pwm_o
);
  logic [N_CH-1:0]              en;
  logic [N_CH-1:0][2*CNT_W-1:0] tim;

  pwm_regfile #(.N_CH(N_CH), .CNT_W(CNT_W), .ADDR_W(ADDR_W)) u_regs (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .wr_en_i (wr_en_i),
    .rd_en_i (rd_en_i),
    .addr_i  (addr_i),
    .wdata_i (wdata_i),
    .rdata_o (rdata_o),
    .en_o    (en),
    .tim_o   (tim)
  );

  for (genvar ch = 0; ch < N_CH; ch++) begin : g_chan
    pwm_chan #(.CNT_W(CNT_W)) u_chan (
      .clk_i  (clk_i),
      .rst_ni (rst_ni),
      .en_i   (en[ch]),
      .tim_i  (tim[ch]),
      .pwm_o  (pwm_o[ch])
    );
  end
endmodule

// File: tb/tb_hl_pwm_ctrl.sv
`timescale 1ns/1ps
module tb_hl_pwm_ctrl;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr_en = 1'b0, rd_en = 1'b0;
  logic [7:0]  addr = '0;
  logic [31:0] wdata = '0;
  logic [31:0] rdata;
  logic [5:0]  pwm;
  int checks = 0, fails = 0;

  always #10 clk = ~clk;

  hl_pwm_ctrl dut (
    .clk_i(clk), .rst_ni(rst_n), .wr_en_i(wr_en), .rd_en_i(rd_en),
    .addr_i(addr), .wdata_i(wdata), .rdata_o(rdata), .pwm_o(pwm)
  );

  function automatic logic [7:0] ctl_a(int c); return 8'(4*c); endfunction
  function automatic logic [7:0] tim_a(int c); return 8'(32 + 4*c); endfunction
  function automatic bit pat(int i, int hi, int lo);
    if (hi + lo == 0) return 1'b0;
    return ((i - 1) % (hi + lo)) < hi;
  endfunction

  task automatic chk(bit ok, string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // all tasks start and end on a falling edge
  task automatic bus_write(logic [7:0] a, logic [31:0] d);
    wr_en = 1'b1; addr = a; wdata = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic bus_read(logic [7:0] a, output logic [31:0] d);
    rd_en = 1'b1; addr = a;
    @(negedge clk);
    rd_en = 1'b0;
    d = rdata;
  endtask

  task automatic t_reset;
    logic [31:0] d;
    bit ok = 1'b1;
    chk(pwm == '0, "R2 outputs", 32'(pwm), 0);
    for (int c = 0; c < 6; c++) begin
      bus_read(ctl_a(c), d); if (d != 0) ok = 1'b0;
      bus_read(tim_a(c), d); if (d != 0) ok = 1'b0;
    end
    chk(ok, "R2 registers zero", {31'b0, ok}, 1);
  endtask

  task automatic t_readback;
    logic [31:0] d;
    bus_write(ctl_a(5), 32'h0000_5A5A);
    bus_write(tim_a(5), 32'hABCD_0123);
    bus_read(ctl_a(5), d); chk(d == 32'h0000_5A5A, "R3 ctrl readback", d, 32'h0000_5A5A);
    bus_read(tim_a(5), d); chk(d == 32'hABCD_0123, "R3 timing readback", d, 32'hABCD_0123);
    bus_write(8'h18, 32'hFFFF_FFFF);
    bus_read(8'h18, d); chk(d == 0, "R3 unmapped slot", d, 0);
    bus_read(8'h40, d); chk(d == 0, "R3 unmapped bank", d, 0);
    // non-enable control bits have no effect
    bus_write(tim_a(2), 32'h0001_0001);
    bus_write(ctl_a(2), 32'h7FFF_FFFF);
    begin
      bit ok = 1'b1;
      for (int i = 0; i < 10; i++) begin @(negedge clk); if (pwm != 0) ok = 1'b0; end
      chk(ok, "R3 low ctrl bits inert", 32'(pwm), 0);
    end
    bus_write(ctl_a(2), 0);
    bus_write(ctl_a(5), 0);
  endtask

  task automatic run_pattern(int c, int hi, int lo, int n, string req);
    int bad_i = 0;
    bit got = 1'b0, ex = 1'b0;
    bus_write(tim_a(c), {16'(hi), 16'(lo)});
    bus_write(ctl_a(c), 32'h8000_0000);
    chk(pwm[c] == 1'b0, {req, " low after enable edge (R5)"}, 32'(pwm[c]), 0);
    for (int i = 1; i <= n; i++) begin
      @(negedge clk);
      if (bad_i == 0 && pwm[c] != pat(i, hi, lo)) begin
        bad_i = i; got = pwm[c]; ex = pat(i, hi, lo);
      end
    end
    chk(bad_i == 0, req, {31'b0, got}, {31'b0, ex});
    if (bad_i != 0) $display("  first mismatch at sample %0d", bad_i);
    bus_write(ctl_a(c), 0);
  endtask

  task automatic t_disable;
    bit ok = 1'b1;
    bus_write(tim_a(3), {16'd10, 16'd10});
    bus_write(ctl_a(3), 32'h8000_0000);
    repeat (3) @(negedge clk);
    chk(pwm[3] == 1'b1, "R6 running high before disable", 32'(pwm[3]), 1);
    bus_write(ctl_a(3), 0);
    chk(pwm[3] == 1'b0, "R6 low right after disable edge", 32'(pwm[3]), 0);
    for (int i = 0; i < 25; i++) begin @(negedge clk); if (pwm[3]) ok = 1'b0; end
    chk(ok, "R6 stays low", {31'b0, ok}, 1);
    // re-enable begins a fresh full high phase
    run_pattern(3, 10, 10, 40, "R5 fresh period after re-enable");
  endtask

  task automatic t_mid_update;
    int bad_i = 0;
    bus_write(tim_a(0), {16'd4, 16'd4});
    bus_write(ctl_a(0), 32'h8000_0000);
    for (int i = 1; i <= 16; i++) begin
      bit e;
      if (i == 3) bus_write(tim_a(0), {16'd2, 16'd2}); else @(negedge clk);
      e = (i <= 8) ? pat(i, 4, 4) : pat(i - 8, 2, 2);
      if (bad_i == 0 && pwm[0] != e) bad_i = i;
    end
    chk(bad_i == 0, "R7 old period completes", 32'(bad_i), 0);
    bus_write(ctl_a(0), 0);
  endtask

  task automatic t_boundary;
    int bad_i = 0;
    bus_write(tim_a(1), {16'd3, 16'd3});
    bus_write(ctl_a(1), 32'h8000_0000);
    for (int i = 1; i <= 12; i++) begin
      bit e;
      // write taken on the edge that ends the first period
      if (i == 7) bus_write(tim_a(1), {16'd1, 16'd2}); else @(negedge clk);
      e = (i <= 6) ? pat(i, 3, 3) : pat(i - 6, 1, 2);
      if (bad_i == 0 && pwm[1] != e) bad_i = i;
    end
    chk(bad_i == 0, "R8 boundary write applies at once", 32'(bad_i), 0);
    bus_write(ctl_a(1), 0);
  endtask

  task automatic t_independent;
    int bad_i = 0;
    bus_write(tim_a(1), {16'd2, 16'd3});
    bus_write(tim_a(4), {16'd4, 16'd1});
    bus_write(ctl_a(1), 32'h8000_0000);
    for (int i = 1; i <= 30; i++) begin
      logic [5:0] e;
      if (i == 1) bus_write(ctl_a(4), 32'h8000_0000); else @(negedge clk);
      e = '0;
      e[1] = pat(i, 2, 3);
      e[4] = (i >= 2) ? pat(i - 1, 4, 1) : 1'b0;
      if (bad_i == 0 && pwm != e) bad_i = i;
    end
    chk(bad_i == 0, "R1 two channels side by side", 32'(bad_i), 0);
    bus_write(ctl_a(1), 0);
    bus_write(ctl_a(4), 0);
    chk(pwm == 0, "R1 all off", 32'(pwm), 0);
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    fails++; checks++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_readback();
    run_pattern(0, 3, 5, 40, "R4 basic 3/5");
    run_pattern(5, 1, 1, 20, "R4 fastest 1/1");
    run_pattern(2, 15000, 10000, 26000, "R4 long 15000/10000");
    t_disable();
    t_mid_update();
    t_boundary();
    t_independent();
    run_pattern(3, 0, 5, 30, "R9 zero high");
    run_pattern(3, 5, 0, 30, "R9 zero low");
    run_pattern(3, 0, 0, 20, "R9 both zero");
    run_pattern(0, 16'hFFFF, 2, 65540, "R10 max high count");
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end
endmodule